// File: doc/BRIEF.md
# Return-to-Zero to Transition Handshake Bridge

This block joins a level-signalled request/acknowledge channel, where every transfer ends with both wires back at zero, to a toggle-signalled channel, where each change of a wire is one event and there is no return to zero. A producer on the level side raises its request with a data word. The bridge captures the word, flips the outgoing toggle request, and waits until the consumer's toggle acknowledge reaches the same level. It then raises the level acknowledge. That acknowledge stays high until the producer lowers its request. Each side therefore sees exactly one transfer per handshake.

The block samples the handshake wires on a single clock and uses a four-state controller: idle, waiting for the toggle acknowledge, acknowledge asserted, and waiting for the request to drop. Synchronizing truly asynchronous inputs is left to the surrounding logic. A parameter chooses whether the data word is held in a register or forwarded unchanged.

Top module: `hs4to2_bridge`

## Requirements
- R1: During and after reset, `tog_req_o`, `lvl_ack_o` and `data_o` are all 0.
- R2: When the controller is idle and `lvl_req_i` is sampled high on a clock edge, `tog_req_o` inverts after that edge. It does not change at any other time.
- R3: In the default capture mode (`HOLD_DATA` = 1), `data_o` takes the value of `data_i` on the edge where the transfer starts. It then holds that value until the next transfer starts, whatever `data_i` does in between.
- R4: `lvl_ack_o` rises only after an edge on which `tog_ack_i` equals `tog_req_o`, and it becomes visible after that edge.
- R5: Once high, `lvl_ack_o` stays high for at least two cycles and for as long as `lvl_req_i` stays high. It falls after the first edge, at least one cycle after it rose, on which `lvl_req_i` is sampled low.
- R6: A change of `tog_ack_i` while no transfer is pending does not raise `lvl_ack_o` and does not change `tog_req_o`.
- R7: Successive transfers flip `tog_req_o` in alternating directions, 0 to 1 and then 1 to 0. Both directions of `tog_ack_i` complete a transfer.
- R8: If `tog_ack_i` already equals the newly flipped `tog_req_o` when a transfer starts, `lvl_ack_o` rises one cycle after `tog_req_o` flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_req_i | input | 1 | Level request from the producer |
| data_i | input | DATA_W | Data bundled with the level request |
| lvl_ack_o | output | 1 | Level acknowledge to the producer |
| tog_req_o | output | 1 | Toggle request to the consumer |
| tog_ack_i | input | 1 | Toggle acknowledge from the consumer |
| data_o | output | DATA_W | Data bundled with the toggle request |

## Verification
The bench changes `data_i` while the acknowledge is high. A design that passed data through instead of capturing it would change `data_o` while the toggle request holds still. The bench holds the request high for many cycles, which exposes an acknowledge that drops early or releases on a timer. It flips the toggle acknowledge while the bridge is idle, which catches a controller that treats any acknowledge edge as completion. That stray flip leaves the two toggle wires out of step, so the next transfer finds them already matching. This checks R8 and catches a design that waits for a fresh edge instead of comparing levels.

// File: rtl/hs_bridge_pkg.sv
package hs_bridge_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_WAIT_TOG  = 2'd1,
      ST_ACK_ON    = 2'd2,
      ST_WAIT_DROP = 2'd3
   } bridge_state_t;
endpackage

// File: rtl/hs_bridge_ctrl.sv
module hs_bridge_ctrl
   import hs_bridge_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_req_i,
   input  logic tog_match_i,
   output logic start_o,
   output logic lvl_ack_o
);
   bridge_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      start_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (lvl_req_i) begin
               start_o = 1'b1;
               state_d = ST_WAIT_TOG;
            end
         end
         ST_WAIT_TOG:  if (tog_match_i) state_d = ST_ACK_ON;
         ST_ACK_ON:    state_d = ST_WAIT_DROP;
         ST_WAIT_DROP: if (!lvl_req_i) state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign lvl_ack_o = (state_q == ST_ACK_ON) || (state_q == ST_WAIT_DROP);
endmodule

// File: rtl/hs_bridge_toggle.sv
module hs_bridge_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic flip_i,
   input  logic tog_ack_i,
   output logic tog_req_o,
   output logic match_o
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      level_q <= 1'b0;
      else if (flip_i) level_q <= ~level_q;
   end

   assign tog_req_o = level_q;
   assign match_o   = (tog_ack_i == level_q);
endmodule

// File: rtl/hs_bridge_hold.sv
module hs_bridge_hold #(
   parameter int  DATA_W    = 8,
   parameter bit  HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [DATA_W-1:0] ZERO_WORD = '0;

   generate
      if (HOLD_DATA) begin : g_capture
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      word_q <= ZERO_WORD;
            else if (load_i) word_q <= data_i;
         end
         assign data_o = word_q;
      end else begin : g_forward
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ load_i;
         assign data_o    = data_i;
      end
   endgenerate
endmodule

// File: rtl/hs4to2_bridge.sv
module hs4to2_bridge #(
   parameter int DATA_W    = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_req_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              lvl_ack_o,
   output logic              tog_req_o,
   input  logic              tog_ack_i,
   output logic [DATA_W-1:0] data_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs4to2_bridge: DATA_W must be at least 1");
      end
   endgenerate

   logic start;
   logic match;

   hs_bridge_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_req_i   (lvl_req_i),
      .tog_match_i (match),
      .start_o     (start),
      .lvl_ack_o   (lvl_ack_o)
   );

   hs_bridge_toggle u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .flip_i    (start),
      .tog_ack_i (tog_ack_i),
      .tog_req_o (tog_req_o),
      .match_o   (match)
   );

   hs_bridge_hold #(.DATA_W(DATA_W), .HOLD_DATA(HOLD_DATA)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .data_i (data_i),
      .data_o (data_o)
   );
endmodule

// File: rtl/hs4to2_bridge_chk.sv
module hs4to2_bridge_chk #(
   parameter int DATA_W    = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lvl_req_i,
   input logic              lvl_ack_o,
   input logic              tog_req_o,
   input logic              tog_ack_i,
   input logic [DATA_W-1:0] data_o
);
   AST_TOG_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(tog_req_o) |-> ($past(lvl_req_i) && !$past(lvl_ack_o))); // R2

   AST_ACK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_ack_o) |-> ($past(tog_ack_i) == $past(tog_req_o))); // R4

   AST_ACK_DROP_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl_ack_o) |-> !$past(lvl_req_i)); // R5

   AST_ACK_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_ack_o) |=> lvl_ack_o); // R5

   AST_NO_FLIP_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_ack_o |=> $stable(tog_req_o)); // R6

   generate
      if (HOLD_DATA) begin : g_data_chk
         AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $changed(data_o) |-> $changed(tog_req_o)); // R3
      end
   endgenerate
endmodule

bind hs4to2_bridge hs4to2_bridge_chk #(.DATA_W(DATA_W), .HOLD_DATA(HOLD_DATA)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lvl_req_i (lvl_req_i),
   .lvl_ack_o (lvl_ack_o),
   .tog_req_o (tog_req_o),
   .tog_ack_i (tog_ack_i),
   .data_o    (data_o)
);

// File: tb/hs4to2_bridge_tb.sv
module hs4to2_bridge_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lvl_req = 1'b0;
   logic [DW-1:0] data_in = '0;
   logic          tog_ack = 1'b0;
   logic          lvl_ack;
   logic          tog_req;
   logic [DW-1:0] data_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // responder control
   bit resp_on    = 1'b1;
   int resp_delay = 0;
   int resp_cnt   = 0;

   // reference model
   int            m_phase = 0;   // 0 idle,1 waiting toggle ack,2 first ack cycle,3 waiting drop
   bit            m_tog   = 1'b0;
   logic [DW-1:0] m_data  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hs4to2_bridge #(.DATA_W(DW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_req_i (lvl_req),
      .data_i    (data_in),
      .lvl_ack_o (lvl_ack),
      .tog_req_o (tog_req),
      .tog_ack_i (tog_ack),
      .data_o    (data_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // model update on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_tog = 1'b0; m_data = '0;
      end else if (m_phase == 0) begin
         if (lvl_req) begin m_tog = ~m_tog; m_data = data_in; m_phase = 1; end
      end else if (m_phase == 1) begin
         if (tog_ack == m_tog) m_phase = 2;
      end else if (m_phase == 2) begin
         m_phase = 3;
      end else if (!lvl_req) begin
         m_phase = 0;
      end
   end

   // per-cycle comparison and responder, at the falling edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check("R2 toggle request", {31'd0, tog_req}, {31'd0, m_tog});
         check("R4 level acknowledge", {31'd0, lvl_ack}, {31'd0, (m_phase >= 2)});
         check("R3 held data", {24'd0, data_out}, {24'd0, m_data});
      end
      if (resp_on && (tog_req != tog_ack)) begin
         if (resp_cnt >= resp_delay) begin
            tog_ack  = tog_req;
            resp_cnt = 0;
         end else resp_cnt++;
      end else resp_cnt = 0;
      if (cycles > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic wait_ack(input bit level);
      while (lvl_ack != level) @(negedge clk);
   endtask

   task automatic transfer(input logic [DW-1:0] d, input int hold);
      @(negedge clk);
      lvl_req = 1'b1; data_in = d;
      wait_ack(1'b1);
      data_in = ~d;                 // R3: must not reach data_out
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         check("R5 ack held while request high", {31'd0, lvl_ack}, 32'd1);
      end
      check("R3 data held after input change", {24'd0, data_out}, {24'd0, d});
      lvl_req = 1'b0;
      wait_ack(1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset toggle request", {31'd0, tog_req}, 32'd0);
      check("R1 reset acknowledge", {31'd0, lvl_ack}, 32'd0);
      check("R1 reset data", {24'd0, data_out}, 32'd0);
      rst_n = 1'b1;

      // basic transfer, immediate responder
      transfer(8'hA5, 0);
      check("R7 first flip goes high", {31'd0, tog_req}, 32'd1);
      // second transfer, responder answers the falling flip
      transfer(8'h3C, 2);
      check("R7 second flip goes low", {31'd0, tog_req}, 32'd0);

      // slow responder: ack must wait for the match
      resp_delay = 6;
      @(negedge clk);
      lvl_req = 1'b1; data_in = 8'h5A;
      repeat (4) @(negedge clk);
      check("R4 no ack before toggle ack", {31'd0, lvl_ack}, 32'd0);
      wait_ack(1'b1);
      check("R4 ack after match", {31'd0, (tog_ack == tog_req)}, 32'd1);
      repeat (10) @(negedge clk);
      check("R5 ack still high with long request", {31'd0, lvl_ack}, 32'd1);
      lvl_req = 1'b0;
      wait_ack(1'b0);
      resp_delay = 0;

      // stray toggle ack while idle
      resp_on = 1'b0;
      @(negedge clk);
      tog_ack = ~tog_ack;
      repeat (5) @(negedge clk);
      check("R6 stray toggle ack leaves ack low", {31'd0, lvl_ack}, 32'd0);
      check("R6 stray toggle ack leaves request", {31'd0, tog_req}, 32'd1);

      // wires now out of step: next start matches at once (R8)
      @(negedge clk);
      lvl_req = 1'b1; data_in = 8'hC3;
      @(negedge clk);
      check("R8 request flipped", {31'd0, tog_req}, 32'd0);
      check("R8 ack not yet", {31'd0, lvl_ack}, 32'd0);
      @(negedge clk);
      check("R8 ack one cycle after flip", {31'd0, lvl_ack}, 32'd1);
      lvl_req = 1'b0;
      @(negedge clk);
      check("R5 minimum acknowledge width", {31'd0, lvl_ack}, 32'd1);
      wait_ack(1'b0);
      resp_on = 1'b1;

      for (int k = 0; k < 6; k++) transfer(DW'(k * 37 + 1), k % 3);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule